// File: doc/BRIEF.md
# Extended-Width Serial Transmitter

This block is the transmit half of an asynchronous serial port. It sends characters of 8, 9 or 10 data bits. Each character is framed by one start bit and one stop bit and advances one bit per baud tick. Software sets up the port through a configuration register. That register holds the character width, the one or two extra data bits that sit above the low byte, an output polarity inversion, a forced break, and the pin direction controls for single-wire half-duplex use.

The low byte of each character goes through a separate data write. That write commits the complete character to a one-entry holding buffer: the byte plus whichever extra bits the selected width needs, all taken from the configuration register at that moment. The extra bits stay in the configuration register until software changes them. A fixed mark or space bit in the upper position therefore needs no rewrite per character. The shift engine takes the buffered character at a baud tick once it is idle or finishing a stop bit. A buffer-empty flag reports when the next byte may be written.

Top module: `wutx_top`

## Requirements
- R1: After reset the configuration reads 0, txd_o is 1, txd_oe is 1, buf_empty is 1 and tx_active is 0.
- R2: A cfg_we cycle stores cfg_wdata, and cfg_rdata returns it from the next cycle. The fields are: bit0 ninth data bit, bit1 tenth data bit, bit2 invert, bit3 pin direction (1 = drive), bit4 single-wire enable, bits 6:5 width (00 = 8 bits, 01 = 9 bits, 10 or 11 = 10 bits), bit7 break.
- R3: A frame is one 0 start bit, the data bits lsb first and one 1 stop bit, each lasting one baud-tick period. The start bit appears at the tick edge where the shifter takes the buffered character, and txd_o changes only at tick edges or configuration writes.
- R4: In 9-bit width, configuration bit0 is sent as the ninth data bit, directly after data bit 7.
- R5: In 10-bit width, bit0 is sent ninth and configuration bit1 tenth, before the stop bit.
- R6: The extra bits are captured at the data write. Changing them while the character waits in the buffer does not alter it. In 8-bit width they are not sent, and the stop bit follows data bit 7.
- R7: The extra bits persist: characters written without a new configuration write carry the same upper bits.
- R8: buf_empty falls at the edge of a data write and rises at the edge where the buffer moves into the shifter. If a data write lands on that same edge, the flag stays 0, the old character is sent and the new one is held.
- R9: When a character is buffered at the end of a stop bit, its start bit follows immediately at the next tick, with no idle period.
- R10: With invert set, txd_o is the complement of the normal level in every state: idle, start, data, stop and break.
- R11: While break is set, the line is held at the space level (0 before inversion), overriding idle and frame bits.
- R12: txd_oe is 0 only when single-wire is set and direction is 0; otherwise it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle pulse per bit period |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write value |
| dat_we | input | 1 | Data write strobe, commits a character |
| dat_wdata | input | DATA_W | Low data byte |
| cfg_rdata | output | 8 | Configuration readback |
| txd_o | output | 1 | Serial output level |
| txd_oe | output | 1 | Output enable for the serial pin |
| buf_empty | output | 1 | Holding buffer empty |
| tx_active | output | 1 | Shifter sending a frame |

## Verification
Two functions can fall on one clock edge. One is a data write, which fills the holding buffer and clears the empty flag. The other is the shifter taking the previous character, which empties the buffer and sets the flag. The bench makes them collide by first filling the buffer while the line is idle. It then holds the next data write across the following baud-tick edge. The design passes if buf_empty stays 0 and tx_active rises at that edge, and both characters then appear intact and back to back on txd_o.

// File: rtl/wutx_pkg.sv
package wutx_pkg;

   // number of data bits that may sit above the low byte
   localparam int EXT_N = 2;
   localparam int CFG_W = 8;

   // configuration layout, msb first
   typedef struct packed {
      logic             brk;
      logic [1:0]       width;
      logic             single;
      logic             drive;
      logic             inv;
      logic [EXT_N-1:0] ext;
   } cfg_t;

   // value equals the number of extension bits in use
   typedef enum logic [1:0] {
      LEN_BASE  = 2'd0,
      LEN_PLUS1 = 2'd1,
      LEN_PLUS2 = 2'd2
   } len_e;

   function automatic len_e width_to_len(input logic [1:0] w);
      case (w)
         2'b00:   return LEN_BASE;
         2'b01:   return LEN_PLUS1;
         default: return LEN_PLUS2;
      endcase
   endfunction

endpackage

// File: rtl/wutx_cfg.sv
module wutx_cfg
   import wutx_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [CFG_W-1:0] wdata,
   output cfg_t             cfg_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else if (we) begin
         cfg_q <= cfg_t'(wdata);
      end
   end

endmodule

// File: rtl/wutx_hold.sv
module wutx_hold
   import wutx_pkg::*;
#(
   parameter int DATA_W = 8,
   localparam int MAX_W = DATA_W + EXT_N
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [DATA_W-1:0] byte_in,
   input  logic [EXT_N-1:0] ext_in,
   input  len_e             len_in,
   input  logic             take,
   output logic [MAX_W-1:0] char_q,
   output len_e             len_q,
   output logic             full_q
);

   // unused upper positions are filled with the stop level so the shifter
   // never needs to know the width while shifting
   logic [MAX_W-1:0] commit;

   assign commit[DATA_W-1:0] = byte_in;

   for (genvar k = 0; k < EXT_N; k++) begin : g_ext
      assign commit[DATA_W+k] = (int'(len_in) > k) ? ext_in[k] : 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         char_q <= '1;
         len_q  <= LEN_BASE;
         full_q <= 1'b0;
      end else begin
         if (wr) begin
            char_q <= commit;
            len_q  <= len_in;
         end
         // a write on the take edge keeps the buffer occupied
         if (wr) begin
            full_q <= 1'b1;
         end else if (take) begin
            full_q <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/wutx_shift.sv
module wutx_shift
   import wutx_pkg::*;
#(
   parameter int DATA_W = 8,
   localparam int MAX_W = DATA_W + EXT_N,
   localparam int CNT_W = $clog2(MAX_W + 2)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             full,
   input  logic [MAX_W-1:0] char_in,
   input  len_e             len_in,
   output logic             take,
   output logic             line_q,
   output logic             active_q
);

   logic [MAX_W-1:0] sh_q;
   logic [CNT_W-1:0] left_q;
   logic             free;

   // idle, or the stop bit of the current frame has run its full period
   assign free = !active_q || (left_q == '0);
   assign take = tick && full && free;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         line_q   <= 1'b1;
         sh_q     <= '1;
         left_q   <= '0;
      end else if (tick) begin
         if (take) begin
            active_q <= 1'b1;
            line_q   <= 1'b0;
            sh_q     <= char_in;
            left_q   <= CNT_W'(DATA_W + 1) + CNT_W'(len_in);
         end else if (active_q && left_q != '0) begin
            line_q   <= sh_q[0];
            sh_q     <= {1'b1, sh_q[MAX_W-1:1]};
            left_q   <= left_q - CNT_W'(1);
         end else if (active_q) begin
            active_q <= 1'b0;
            line_q   <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/wutx_line.sv
module wutx_line
   import wutx_pkg::*;
(
   input  logic line_raw,
   input  cfg_t cfg,
   output logic txd_o,
   output logic txd_oe
);

   logic level;

   assign level  = cfg.brk ? 1'b0 : line_raw;
   assign txd_o  = level ^ cfg.inv;
   assign txd_oe = !cfg.single || cfg.drive;

endmodule

// File: rtl/wutx_top.sv
module wutx_top
   import wutx_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              baud_tick,
   input  logic              cfg_we,
   input  logic [7:0]        cfg_wdata,
   input  logic              dat_we,
   input  logic [DATA_W-1:0] dat_wdata,
   output logic [7:0]        cfg_rdata,
   output logic              txd_o,
   output logic              txd_oe,
   output logic              buf_empty,
   output logic              tx_active
);

   localparam int MAX_W = DATA_W + EXT_N;

   if (DATA_W < 5 || DATA_W > 16) begin : g_bad_width
      $error("wutx_top: DATA_W must lie in 5..16");
   end
   if (CFG_W != 8) begin : g_bad_cfg
      $error("wutx_top: configuration layout must be 8 bits");
   end

   cfg_t             cfg_q;
   logic [MAX_W-1:0] hold_char;
   len_e             hold_len;
   logic             hold_full;
   logic             take;
   logic             line_raw;

   wutx_cfg u_cfg (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cfg_we),
      .wdata (cfg_wdata),
      .cfg_q (cfg_q)
   );

   wutx_hold #(.DATA_W(DATA_W)) u_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (dat_we),
      .byte_in (dat_wdata),
      .ext_in  (cfg_q.ext),
      .len_in  (width_to_len(cfg_q.width)),
      .take    (take),
      .char_q  (hold_char),
      .len_q   (hold_len),
      .full_q  (hold_full)
   );

   wutx_shift #(.DATA_W(DATA_W)) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (baud_tick),
      .full     (hold_full),
      .char_in  (hold_char),
      .len_in   (hold_len),
      .take     (take),
      .line_q   (line_raw),
      .active_q (tx_active)
   );

   wutx_line u_line (
      .line_raw (line_raw),
      .cfg      (cfg_q),
      .txd_o    (txd_o),
      .txd_oe   (txd_oe)
   );

   assign cfg_rdata = cfg_q;
   assign buf_empty = !hold_full;

endmodule

// File: rtl/wutx_check.sv
module wutx_check (
   input logic       clk,
   input logic       rst_n,
   input logic       baud_tick,
   input logic       cfg_we,
   input logic       dat_we,
   input logic [7:0] cfg_rdata,
   input logic       txd_o,
   input logic       txd_oe,
   input logic       buf_empty,
   input logic       tx_active
);

   p_oe_input_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_rdata[4] && !cfg_rdata[3]) |-> !txd_oe);

   p_oe_drive_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_rdata[4] || cfg_rdata[3]) |-> txd_oe);

   p_write_fills_r8: assert property (@(posedge clk) disable iff (!rst_n)
      dat_we |=> !buf_empty);

   p_empty_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_empty && !dat_we) |=> buf_empty);

   p_start_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tx_active) |-> $past(baud_tick));

   p_quiet_between_ticks_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!baud_tick && !cfg_we) |=> $stable(txd_o));

   p_break_space_r11: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_rdata[7] |-> (txd_o == cfg_rdata[2]));

   p_idle_mark_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_active && !cfg_rdata[7]) |-> (txd_o == !cfg_rdata[2]));

endmodule

bind wutx_top wutx_check u_check (
   .clk       (clk),
   .rst_n     (rst_n),
   .baud_tick (baud_tick),
   .cfg_we    (cfg_we),
   .dat_we    (dat_we),
   .cfg_rdata (cfg_rdata),
   .txd_o     (txd_o),
   .txd_oe    (txd_oe),
   .buf_empty (buf_empty),
   .tx_active (tx_active)
);

// File: tb/wutx_top_test.sv
`timescale 1ns/1ps
module wutx_top_test;

   localparam int DATA_W = 8;
   localparam int DIV    = 6;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              baud_tick;
   logic              cfg_we = 1'b0;
   logic [7:0]        cfg_wdata = '0;
   logic              dat_we = 1'b0;
   logic [DATA_W-1:0] dat_wdata = '0;
   logic [7:0]        cfg_rdata;
   logic              txd_o, txd_oe, buf_empty, tx_active;

   int total = 0;
   int bad   = 0;
   int tick_cnt = 0;
   bit timed_out = 1'b0;

   always #4 clk = ~clk;

   always @(posedge clk) tick_cnt <= (tick_cnt == DIV - 1) ? 0 : tick_cnt + 1;
   assign baud_tick = (tick_cnt == DIV - 1);

   wutx_top #(.DATA_W(DATA_W)) uut (
      .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
      .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .dat_we(dat_we), .dat_wdata(dat_wdata),
      .cfg_rdata(cfg_rdata), .txd_o(txd_o), .txd_oe(txd_oe),
      .buf_empty(buf_empty), .tx_active(tx_active)
   );

   task automatic check(input bit ok, input string tag,
                        input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic put_cfg(input logic [7:0] v);
      @(negedge clk);
      cfg_we = 1'b1; cfg_wdata = v;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic put_byte(input logic [7:0] v);
      @(negedge clk);
      dat_we = 1'b1; dat_wdata = v;
      @(negedge clk);
      dat_we = 1'b0;
   endtask

   // returns at the negedge just after the next tick edge
   task automatic wait_tick_edge();
      do @(negedge clk); while (!baud_tick);
      @(negedge clk);
   endtask

   task automatic wait_idle();
      do @(negedge clk); while (tx_active || !buf_empty);
   endtask

   // got[n-1:0] are data bits, got[n] the stop bit, normal polarity
   task automatic capture(input int n, input bit inv, input bit now,
                          input string tag, output logic [15:0] got);
      logic raw;
      got = '0;
      wait_tick_edge();
      raw = txd_o ^ inv;
      if (now) check(raw == 1'b0, tag, raw, 0);
      while (raw != 1'b0) begin
         wait_tick_edge();
         raw = txd_o ^ inv;
      end
      for (int i = 0; i <= n; i++) begin
         wait_tick_edge();
         got[i] = txd_o ^ inv;
      end
   endtask

   function automatic logic [15:0] frame(input int n, input logic [15:0] c);
      return (c & ((16'd1 << n) - 16'd1)) | (16'd1 << n);
   endfunction

   task automatic t_reset();
      check(cfg_rdata == 8'h00, "R1 cfg", cfg_rdata, 0);
      check(txd_o == 1'b1, "R1 txd idle", txd_o, 1);
      check(txd_oe == 1'b1, "R1 oe", txd_oe, 1);
      check(buf_empty == 1'b1, "R1 empty", buf_empty, 1);
      check(tx_active == 1'b0, "R1 active", tx_active, 0);
   endtask

   task automatic t_readback();
      put_cfg(8'h63);
      check(cfg_rdata == 8'h63, "R2 readback", cfg_rdata, 8'h63);
      put_cfg(8'h00);
      check(cfg_rdata == 8'h00, "R2 clear", cfg_rdata, 0);
   endtask

   task automatic t_eight();
      logic [15:0] g;
      put_cfg(8'h03);  // width 8, both extension bits 0? no: set to 1
      fork
         capture(8, 1'b0, 1'b0, "R3 start", g);
         put_byte(8'h4B);
      join
      check(g == frame(8, 16'h04B), "R3 frame 8-bit lsb first", g, frame(8, 16'h04B));
      check(g[8] == 1'b1, "R6 stop follows bit7 in 8-bit", g[8], 1);
      wait_idle();
   endtask

   task automatic t_nine();
      logic [15:0] g;
      put_cfg(8'h21);
      fork
         capture(9, 1'b0, 1'b0, "R4 start", g);
         put_byte(8'h3C);
      join
      check(g == frame(9, 16'h13C), "R4 ninth bit", g, frame(9, 16'h13C));
      wait_idle();
      fork
         capture(9, 1'b0, 1'b0, "R7 start", g);
         put_byte(8'hC3);
      join
      check(g == frame(9, 16'h1C3), "R7 sticky ninth bit", g, frame(9, 16'h1C3));
      wait_idle();
   endtask

   task automatic t_ten();
      logic [15:0] g;
      put_cfg(8'h42);
      fork
         capture(10, 1'b0, 1'b0, "R5 start", g);
         put_byte(8'h81);
      join
      check(g == frame(10, 16'h281), "R5 tenth bit", g, frame(10, 16'h281));
      wait_idle();
   endtask

   task automatic t_commit();
      logic [15:0] g1, g2;
      put_cfg(8'h20);
      fork
         begin
            capture(9, 1'b0, 1'b0, "R3 start", g1);
            capture(9, 1'b0, 1'b1, "R9 no gap", g2);
         end
         begin
            put_byte(8'h11);
            check(buf_empty == 1'b0, "R8 write clears empty", buf_empty, 0);
            while (!tx_active) @(negedge clk);
            check(buf_empty == 1'b1, "R8 empty on move", buf_empty, 1);
            put_byte(8'h22);
            check(buf_empty == 1'b0, "R8 refill", buf_empty, 0);
            put_cfg(8'h21);
         end
      join
      check(g1 == frame(9, 16'h011), "R6 first char", g1, frame(9, 16'h011));
      check(g2 == frame(9, 16'h022), "R6 committed ninth bit kept", g2, frame(9, 16'h022));
      wait_idle();
   endtask

   task automatic t_collide();
      logic [15:0] g1, g2;
      put_cfg(8'h00);
      wait_idle();
      fork
         begin
            capture(8, 1'b0, 1'b0, "R8 start", g1);
            capture(8, 1'b0, 1'b1, "R9 no gap after collision", g2);
         end
         begin
            do @(negedge clk); while (baud_tick);
            dat_we = 1'b1; dat_wdata = 8'hA7;
            @(negedge clk);
            dat_we = 1'b0;
            while (!baud_tick) @(negedge clk);
            dat_we = 1'b1; dat_wdata = 8'h3E;
            @(negedge clk);
            dat_we = 1'b0;
            check(buf_empty == 1'b0, "R8 collision keeps full", buf_empty, 0);
            check(tx_active == 1'b1, "R8 collision starts frame", tx_active, 1);
         end
      join
      check(g1 == frame(8, 16'h0A7), "R8 old char sent", g1, frame(8, 16'h0A7));
      check(g2 == frame(8, 16'h03E), "R8 new char sent", g2, frame(8, 16'h03E));
      wait_idle();
   endtask

   task automatic t_invert();
      logic [15:0] g;
      put_cfg(8'h04);
      check(txd_o == 1'b0, "R10 idle inverted", txd_o, 0);
      fork
         capture(8, 1'b1, 1'b0, "R10 start", g);
         put_byte(8'h5A);
      join
      check(g == frame(8, 16'h05A), "R10 frame inverted", g, frame(8, 16'h05A));
      wait_idle();
      put_cfg(8'h84);
      check(txd_o == 1'b1, "R10 break inverted", txd_o, 1);
      put_cfg(8'h80);
      check(txd_o == 1'b0, "R11 break space", txd_o, 0);
      put_cfg(8'h00);
      check(txd_o == 1'b1, "R11 break released", txd_o, 1);
   endtask

   task automatic t_oe();
      put_cfg(8'h10);
      check(txd_oe == 1'b0, "R12 single-wire input", txd_oe, 0);
      put_cfg(8'h18);
      check(txd_oe == 1'b1, "R12 single-wire drive", txd_oe, 1);
      put_cfg(8'h08);
      check(txd_oe == 1'b1, "R12 full duplex", txd_oe, 1);
      put_cfg(8'h00);
   endtask

   initial begin
      fork
         begin
            repeat (3) @(negedge clk);
            rst_n = 1'b1;
            @(negedge clk);
            t_reset();
            t_readback();
            t_eight();
            t_nine();
            t_ten();
            t_commit();
            t_collide();
            t_invert();
            t_oe();
         end
         begin
            repeat (20000) @(posedge clk);
            timed_out = 1'b1;
         end
      join_any
      disable fork;
      if (timed_out) begin
         total++;
         bad++;
         $display("FAIL watchdog (all R) actual=expired expected=done");
      end
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule